// File: doc/BRIEF.md
# SDRAM refresh and power-state sequencer

This block sits on the controller side of a two-bank SDRAM and owns the clock-enable pin and the command bus whenever the memory must be refreshed or moved between power states. It counts out the refresh interval from a clock-frequency parameter and issues AUTO REFRESH when a refresh falls due. It also carries the memory into and out of self refresh and power down on request. When a bank is still open, it first closes every bank with one precharge-all command and observes the precharge time. It then keeps the command bus at NOP for the full row-cycle time.

A user-side arbiter watches `usr_grant`. It may drive read and write traffic only while grant is high, and it raises `usr_busy` while a burst must not be broken. A refresh that falls due during a burst or during power down is counted as pending. It is serviced at the next allowed point. Once the pending count reaches a parameterised limit, the refresh is forced. The arbiter reports bank activations and single-bank precharges, so the block always knows whether any bank is open. It reports the power state in effect on `pd_mode`.

Top module: `sdr_pwr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, CKE is high, the command is NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), grant is high and `pd_mode` is 00.
- R2: A refresh falls due every REF_CYC = CLK_MHZ*156/10 cycles. If no bank is open and the user is not busy, the AUTO REFRESH code 0001 goes out with CKE high two cycles after the cycle in which it falls due.
- R3: If a refresh or self-refresh entry starts while any bank is open, the block first issues PRECHARGE ALL (code 0010 with `sd_a10` high). It then sends NOPs so that the next command follows T_RP cycles after the precharge, and it records every bank as closed.
- R4: After an AUTO REFRESH, T_RC-1 NOP cycles follow with grant low. No precharge is issued afterwards, and the banks stay closed.
- R5: While `usr_busy` is high, a due refresh is held pending. When the pending count reaches MAX_POSTPONE, the refresh starts regardless of `usr_busy`. The pending count never exceeds MAX_POSTPONE.
- R6: Self-refresh entry drives CKE low for one cycle together with code 0001. CKE then stays low with NOP while `sr_req` is high, and `pd_mode` reads 11. The refresh interval counter is held at zero, and the pending refreshes are cleared.
- R7: When `sr_req` falls during self refresh, CKE rises and T_RC NOP cycles follow with grant low before the block returns to idle.
- R8: `pd_req` with `usr_busy` low drives CKE low with NOP. `pd_mode` reads 10 (active power down) while any bank is open and 01 (precharge power down) while both banks are closed.
- R9: When power down ends, CKE rises and T_XP NOP cycles follow with grant low before grant can return.
- R10: Refreshes that fall due during power down are counted as pending. When the count reaches MAX_POSTPONE, power down is left through the R9 exit and the refresh is then issued.
- R11: When several starts are possible in the same idle cycle, a due refresh wins over self-refresh entry, and self-refresh entry wins over power down.
- R12: Grant is high only in idle cycles in which no refresh, self refresh or power down starts. Grant high implies CKE high and a NOP command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usr_busy | input | 1 | User burst in progress; defers refresh and power transitions |
| pd_req | input | 1 | Level request for power down |
| sr_req | input | 1 | Level request for self refresh |
| bank_act | input | NUM_BANKS | One pulse per bank activated by the user side |
| bank_pre | input | NUM_BANKS | One pulse per bank precharged by the user side |
| usr_grant | output | 1 | User side may issue commands this cycle |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cmd | output | 4 | `{cs_n,ras_n,cas_n,we_n}` command code |
| sd_a10 | output | 1 | Address bit 10; high selects all banks for precharge |
| pd_mode | output | 2 | 00 awake, 01 precharge power down, 10 active power down, 11 self refresh |

## Verification
Two functions can fall in the same cycle: a refresh coming due and a power-state request. The bench holds `usr_busy` high until a refresh is pending, raises `sr_req` and `pd_req` together, and then releases `usr_busy`. All three starts then compete in one idle cycle. It also lets ticks arrive while the memory sits in power down, so the pending count hits its limit inside that state. A behavioural reference model built from the requirements predicts CKE, command, A10, grant and `pd_mode` on every clock. Each cycle is judged against that prediction, so the order refresh, then self refresh, then power down, and the forced exit from power down are checked cycle for cycle.

// File: rtl/sps_pkg.sv
// Shared definitions for the SDRAM refresh and power-state sequencer.
// Assumes: command bus is {cs_n, ras_n, cas_n, we_n}.
package sps_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_WRP, ST_REF, ST_WRC,
        ST_SRE, ST_SR, ST_PD, ST_PDX
    } sps_state_e;

    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;

    localparam logic [1:0] PM_AWAKE = 2'b00;
    localparam logic [1:0] PM_PPD   = 2'b01;
    localparam logic [1:0] PM_APD   = 2'b10;
    localparam logic [1:0] PM_SELF  = 2'b11;
endpackage

// File: rtl/sps_ref_timer.sv
// Refresh interval counter and pending-refresh count.
// Counts REF_CYC cycles per interval and adds one pending refresh per interval,
// saturating at MAX_POST. Assumes take is only raised while pend is nonzero.
module sps_ref_timer #(
    parameter int REF_CYC  = 1560,
    parameter int MAX_POST = 2,
    localparam int TW = $clog2(REF_CYC),
    localparam int PW = $clog2(MAX_POST + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clear,
    input  logic take,
    output logic due,
    output logic full
);
    localparam logic [TW-1:0] TIM_LAST = TW'(REF_CYC - 1);
    localparam logic [PW-1:0] PEND_MAX = PW'(MAX_POST);

    logic [TW-1:0] tim;
    logic [PW-1:0] pend;
    logic          tick;

    // interval expiry, suppressed while held
    always_comb tick = !hold && (tim == TIM_LAST);

    // interval counter: cleared on reset or hold, wraps on expiry
    always_ff @(posedge clk) begin
        if (!rst_n || hold)  tim <= '0;
        else if (tick)       tim <= '0;
        else                 tim <= tim + 1'b1;
    end

    // pending count: up on expiry (saturating), down when a refresh goes out
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pend <= '0;
        else begin
            case ({tick, take})
                2'b10:   if (pend != PEND_MAX) pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    // status for the sequencer
    always_comb begin
        due  = (pend != '0);
        full = (pend == PEND_MAX);
    end
endmodule

// File: rtl/sps_bank_track.sv
// Open-bank tracker: one flag per bank, set by activation, cleared by a
// single-bank precharge or by the sequencer's precharge-all.
module sps_bank_track #(
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] act,
    input  logic [NUM_BANKS-1:0] pre,
    input  logic                 pre_all,
    output logic                 any_open,
    output logic [NUM_BANKS-1:0] open_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // per-bank open flag; precharge-all takes precedence
        always_ff @(posedge clk) begin
            if (!rst_n || pre_all) open_q[b] <= 1'b0;
            else if (pre[b])       open_q[b] <= 1'b0;
            else if (act[b])       open_q[b] <= 1'b1;
        end
    end

    // any bank open
    always_comb any_open = |open_q;
endmodule

// File: rtl/sps_fsm.sv
// Sequencer state machine: picks refresh, self refresh or power down from idle,
// inserts precharge-all when banks are open, and times tRP, tRC and exit latency.
// Assumes T_RP >= 2, T_RC >= 2, T_XP >= 1.
module sps_fsm
    import sps_pkg::*;
#(
    parameter int T_RP = 3,
    parameter int T_RC = 7,
    parameter int T_XP = 2,
    localparam int TMAX = (T_RC > T_RP) ? ((T_RC > T_XP) ? T_RC : T_XP)
                                        : ((T_RP > T_XP) ? T_RP : T_XP),
    localparam int CW = $clog2(TMAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       usr_busy,
    input  logic       pd_req,
    input  logic       sr_req,
    input  logic       due,
    input  logic       full,
    input  logic       any_open,
    output logic       grant,
    output logic       cke,
    output logic [3:0] cmd,
    output logic       a10,
    output logic [1:0] pd_mode,
    output logic       take,
    output logic       pre_all,
    output logic       tim_hold,
    output logic       pend_clr
);
    localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 2);
    localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 2);
    localparam logic [CW-1:0] LD_SRX = CW'(T_RC - 1);
    localparam logic [CW-1:0] LD_XP  = CW'(T_XP - 1);

    sps_state_e    st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          tgt_sr, tgt_sr_n;
    logic          ref_go, sr_go, pd_go;

    // start conditions seen from idle
    always_comb begin
        ref_go = due && (!usr_busy || full);
        sr_go  = sr_req && !usr_busy;
        pd_go  = pd_req && !usr_busy;
    end

    // next-state, wait counter and precharge target selection
    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        tgt_sr_n = tgt_sr;
        case (st)
            ST_IDLE: begin
                if (ref_go) begin
                    st_n     = any_open ? ST_PRE : ST_REF;
                    tgt_sr_n = 1'b0;
                end else if (sr_go) begin
                    st_n     = any_open ? ST_PRE : ST_SRE;
                    tgt_sr_n = 1'b1;
                end else if (pd_go) begin
                    st_n     = ST_PD;
                end
            end
            ST_PRE: begin
                st_n  = ST_WRP;
                cnt_n = LD_RP;
            end
            ST_WRP: begin
                if (cnt == '0) st_n = tgt_sr ? ST_SRE : ST_REF;
                else           cnt_n = cnt - 1'b1;
            end
            ST_REF: begin
                st_n  = ST_WRC;
                cnt_n = LD_RC;
            end
            ST_WRC, ST_PDX: begin
                if (cnt == '0) st_n = ST_IDLE;
                else           cnt_n = cnt - 1'b1;
            end
            ST_SRE: st_n = ST_SR;
            ST_SR: begin
                if (!sr_req) begin
                    st_n  = ST_WRC;
                    cnt_n = LD_SRX;
                end
            end
            ST_PD: begin
                if (!pd_req || full) begin
                    st_n  = ST_PDX;
                    cnt_n = LD_XP;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            tgt_sr <= 1'b0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            tgt_sr <= tgt_sr_n;
        end
    end

    // pin and handshake decode from the current state
    always_comb begin
        cke      = !(st == ST_SRE || st == ST_SR || st == ST_PD);
        a10      = (st == ST_PRE);
        pre_all  = (st == ST_PRE);
        take     = (st == ST_REF);
        tim_hold = (st == ST_SRE || st == ST_SR);
        pend_clr = (st == ST_SRE);
        grant    = (st == ST_IDLE) && !(ref_go || sr_go || pd_go);
        case (st)
            ST_PRE:         cmd = CMD_PRE;
            ST_REF, ST_SRE: cmd = CMD_REF;
            default:        cmd = CMD_NOP;
        endcase
        case (st)
            ST_SRE, ST_SR: pd_mode = PM_SELF;
            ST_PD:         pd_mode = any_open ? PM_APD : PM_PPD;
            default:       pd_mode = PM_AWAKE;
        endcase
    end
endmodule

// File: rtl/sdr_pwr_seq.sv
// Top of the SDRAM refresh and power-state sequencer.
// Derives the refresh interval from CLK_MHZ (15.6 us per refresh) and ties the
// interval timer, open-bank tracker and state machine together.
module sdr_pwr_seq #(
    parameter int CLK_MHZ   = 100,
    parameter int T_RP      = 3,
    parameter int T_RC      = 7,
    parameter int T_XP      = 2,
    parameter int MAX_POST  = 2,
    parameter int NUM_BANKS = 2,
    localparam int REF_CYC  = (CLK_MHZ * 156) / 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 usr_busy,
    input  logic                 pd_req,
    input  logic                 sr_req,
    input  logic [NUM_BANKS-1:0] bank_act,
    input  logic [NUM_BANKS-1:0] bank_pre,
    output logic                 usr_grant,
    output logic                 sd_cke,
    output logic [3:0]           sd_cmd,
    output logic                 sd_a10,
    output logic [1:0]           pd_mode
);
    logic due, full, any_open, take, pre_all, tim_hold, pend_clr;
    logic [NUM_BANKS-1:0] open_q;

    sps_ref_timer #(.REF_CYC(REF_CYC), .MAX_POST(MAX_POST)) u_timer (
        .clk(clk), .rst_n(rst_n), .hold(tim_hold), .clear(pend_clr),
        .take(take), .due(due), .full(full)
    );

    sps_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk(clk), .rst_n(rst_n), .act(bank_act), .pre(bank_pre),
        .pre_all(pre_all), .any_open(any_open), .open_q(open_q)
    );

    sps_fsm #(.T_RP(T_RP), .T_RC(T_RC), .T_XP(T_XP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .usr_busy(usr_busy), .pd_req(pd_req),
        .sr_req(sr_req), .due(due), .full(full), .any_open(any_open),
        .grant(usr_grant), .cke(sd_cke), .cmd(sd_cmd), .a10(sd_a10),
        .pd_mode(pd_mode), .take(take), .pre_all(pre_all),
        .tim_hold(tim_hold), .pend_clr(pend_clr)
    );
endmodule

// File: rtl/sps_chk.sv
// Protocol checker for the sequencer's memory-side pins and grant.
module sps_chk
    import sps_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       usr_grant,
    input logic       sd_cke,
    input logic [3:0] sd_cmd,
    input logic       sd_a10,
    input logic [1:0] pd_mode
);
    // R12
    grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_grant |-> (sd_cke && sd_cmd == CMD_NOP));

    // R4
    ref_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke && sd_cmd == CMD_REF) |=> (sd_cmd == CMD_NOP && !usr_grant));

    // R3
    pre_all_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_PRE) |-> sd_a10);

    // R3
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_PRE) |=> (sd_cmd == CMD_NOP && !usr_grant));

    // R6
    self_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sd_cke) && pd_mode == PM_SELF) |-> (sd_cmd == CMD_REF));

    // R6
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && !$fell(sd_cke)) |-> (sd_cmd == CMD_NOP));

    // R8
    pd_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mode == PM_PPD || pd_mode == PM_APD) |-> !sd_cke);

    // R9
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_cke) |-> !usr_grant);
endmodule

bind sdr_pwr_seq sps_chk u_chk (
    .clk(clk), .rst_n(rst_n), .usr_grant(usr_grant), .sd_cke(sd_cke),
    .sd_cmd(sd_cmd), .sd_a10(sd_a10), .pd_mode(pd_mode)
);

// File: tb/sdr_pwr_seq_bench.sv
// Bench: behavioural cycle model of the sequencer compared on every clock.
module sdr_pwr_seq_bench;
    localparam int CLK_MHZ = 10;
    localparam int REFC    = (CLK_MHZ * 156) / 10;
    localparam int TRP     = 3;
    localparam int TRC     = 6;
    localparam int TXP     = 2;
    localparam int MAXP    = 2;

    localparam int M_IDLE = 0, M_PRE = 1, M_WRP = 2, M_REF = 3, M_WRC = 4,
                   M_SRE = 5, M_SR = 6, M_PD = 7, M_PDX = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic usr_busy = 1'b0, pd_req = 1'b0, sr_req = 1'b0;
    logic [1:0] bank_act = 2'b00, bank_pre = 2'b00;
    logic usr_grant, sd_cke, sd_a10;
    logic [3:0] sd_cmd;
    logic [1:0] pd_mode;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    int mst, mcnt, mtim, mpend;
    bit mtgt, mfromsr;
    bit [1:0] mopen;

    always #5 clk = ~clk;

    sdr_pwr_seq #(.CLK_MHZ(CLK_MHZ), .T_RP(TRP), .T_RC(TRC), .T_XP(TXP),
                  .MAX_POST(MAXP), .NUM_BANKS(2)) u_sdr_pwr_seq (
        .clk(clk), .rst_n(rst_n), .usr_busy(usr_busy), .pd_req(pd_req),
        .sr_req(sr_req), .bank_act(bank_act), .bank_pre(bank_pre),
        .usr_grant(usr_grant), .sd_cke(sd_cke), .sd_cmd(sd_cmd),
        .sd_a10(sd_a10), .pd_mode(pd_mode)
    );

    // reference model state update
    always @(posedge clk) begin
        bit rgo, sgo, pgo, hold, tick;
        int nst;
        if (!rst_n) begin
            mst = M_IDLE; mcnt = 0; mtim = 0; mpend = 0;
            mtgt = 0; mfromsr = 0; mopen = 2'b00;
        end else begin
            rgo  = (mpend > 0) && (!usr_busy || mpend == MAXP);
            sgo  = sr_req && !usr_busy;
            pgo  = pd_req && !usr_busy;
            hold = (mst == M_SRE || mst == M_SR);
            tick = !hold && (mtim == REFC - 1);
            nst  = mst;
            case (mst)
                M_IDLE: if (rgo) begin nst = (mopen != 0) ? M_PRE : M_REF; mtgt = 0; end
                        else if (sgo) begin nst = (mopen != 0) ? M_PRE : M_SRE; mtgt = 1; end
                        else if (pgo) nst = M_PD;
                M_PRE:  begin nst = M_WRP; mcnt = TRP - 1; end
                M_WRP:  begin mcnt--; if (mcnt == 0) nst = mtgt ? M_SRE : M_REF; end
                M_REF:  begin nst = M_WRC; mcnt = TRC - 1; mfromsr = 0; end
                M_WRC:  begin mcnt--; if (mcnt == 0) nst = M_IDLE; end
                M_SRE:  nst = M_SR;
                M_SR:   if (!sr_req) begin nst = M_WRC; mcnt = TRC; mfromsr = 1; end
                M_PD:   if (!pd_req || mpend == MAXP) begin nst = M_PDX; mcnt = TXP; end
                M_PDX:  begin mcnt--; if (mcnt == 0) nst = M_IDLE; end
                default: nst = M_IDLE;
            endcase
            if (hold || tick) mtim = 0; else mtim++;
            if (mst == M_SRE) mpend = 0;
            else if (mst == M_REF && !tick) mpend--;
            else if (tick && mst != M_REF && mpend < MAXP) mpend++;
            if (mst == M_PRE) mopen = 2'b00;
            else mopen = (mopen | bank_act) & ~bank_pre;
            mst = nst;
        end
    end

    // compare DUT with model away from the active edge
    always @(negedge clk) begin
        bit rgo, sgo, pgo, e_cke, e_a10, e_gnt;
        logic [3:0] e_cmd;
        logic [1:0] e_mode;
        string tag;
        rgo = (mpend > 0) && (!usr_busy || mpend == MAXP);
        sgo = sr_req && !usr_busy;
        pgo = pd_req && !usr_busy;
        if (!rst_n) begin
            e_cke = 1; e_a10 = 0; e_gnt = 1; e_cmd = 4'b0111; e_mode = 2'b00;
        end else begin
            e_cke = !(mst == M_SRE || mst == M_SR || mst == M_PD);
            e_a10 = (mst == M_PRE);
            e_gnt = (mst == M_IDLE) && !(rgo || sgo || pgo);
            e_cmd = (mst == M_PRE) ? 4'b0010 :
                    (mst == M_REF || mst == M_SRE) ? 4'b0001 : 4'b0111;
            e_mode = (mst == M_SRE || mst == M_SR) ? 2'b11 :
                     (mst == M_PD) ? ((mopen != 0) ? 2'b10 : 2'b01) : 2'b00;
        end
        if (!rst_n || cyc < 2) tag = "R1";
        else case (mst)
            M_IDLE: tag = ((rgo && (sgo || pgo)) || (sgo && pgo)) ? "R11" :
                          (rgo && usr_busy) ? "R5" : "R12";
            M_PRE, M_WRP: tag = "R3";
            M_REF:   tag = "R2";
            M_WRC:   tag = mfromsr ? "R7" : "R4";
            M_SRE, M_SR: tag = "R6";
            M_PD:    tag = (mpend == MAXP) ? "R10" : "R8";
            default: tag = "R9";
        endcase
        checks++;
        if ({sd_cke, sd_cmd, sd_a10, usr_grant, pd_mode} !==
            {e_cke, e_cmd, e_a10, e_gnt, e_mode}) begin
            errors++;
            $display("FAIL %s cyc=%0d actual cke=%b cmd=%b a10=%b gnt=%b mode=%b expected cke=%b cmd=%b a10=%b gnt=%b mode=%b",
                     tag, cyc, sd_cke, sd_cmd, sd_a10, usr_grant, pd_mode,
                     e_cke, e_cmd, e_a10, e_gnt, e_mode);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual cyc=%0d expected end before 20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_act(input logic [1:0] b);
        bank_act = b; step(1); bank_act = 2'b00;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(350);                              // R2 idle refreshes
        pulse_act(2'b01); step(200);            // R3 precharge before refresh
        bank_pre = 2'b00;
        usr_busy = 1'b1; pulse_act(2'b10);      // R5 postponed then forced
        step(400); usr_busy = 1'b0; step(20);
        pulse_act(2'b01); pd_req = 1'b1;        // R8 active power down
        step(60); pd_req = 1'b0; step(20);      // R9 exit latency
        bank_pre = 2'b01; step(1); bank_pre = 2'b00;
        pd_req = 1'b1; step(500);               // R10 forced exit for refresh
        pd_req = 1'b0; step(30);
        pulse_act(2'b10); sr_req = 1'b1;        // R6 self refresh
        step(300); sr_req = 1'b0; step(30);     // R7 exit lockout
        usr_busy = 1'b1; step(170);             // R11 competing starts
        sr_req = 1'b1; pd_req = 1'b1; step(5);
        usr_busy = 1'b0; step(100);
        sr_req = 1'b0; step(40);
        pd_req = 1'b0; step(30);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule